// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block picks the handshake a USB device's control endpoint returns for every decoded token. It follows a control transfer through its stages: a SETUP token opens the transfer, an optional data stage follows, and a status stage closes it. It also keeps the endpoint's data toggle up to date. Two firmware-armed enable flags govern the transfer. One opens the data stage and clears itself after each data packet that completes. The other opens the status stage and clears itself once the zero-length status handshake finishes. Until firmware arms the matching flag, the block answers with NAK. This gives firmware time to decode the request, which is announced by a one-cycle setup-done pulse.

A separate stall flag makes the endpoint answer IN and OUT tokens with STALL. The stall flag has no effect on isochronous endpoints. Stalling never touches the data toggle. The toggle returns to DATA0 only when the endpoint is disabled, or when a SETUP token arrives. Packet serialization, CRC and buffer storage sit in neighbouring blocks. Those blocks supply the decoded tokens, the data-ready indication and host ACK detection.

Top module: `ctl_hs_responder`

## Requirements
- R1: A SETUP token (token code 0) on an enabled endpoint is answered with ACK (response code 1), even while stalled. It pulses setup_done together with the response and restarts stage tracking. It clears the stall, data-stage and status flags, and leaves toggle at 1: the setup packet counts as DATA0 and the handshake succeeded.
- R2: After SETUP, IN (code 1) and OUT (code 2) tokens get NAK (response code 0) while the data-stage flag is clear.
- R3: With the data-stage flag set, an OUT token gets ACK and clears the flag. An IN token gets send-data (response code 3) if data_ready is high, and NAK otherwise. After send-data, host_ack clears the flag.
- R4: dsen_rd always reads 0, whether or not the data-stage flag is set.
- R5: With the status flag clear, tokens after SETUP that are not answered by the data stage get NAK. With the status flag set, an IN token gets send-zero-length (response code 4) and an OUT token gets ACK. The status flag takes priority over the data-stage flag.
- R6: The status flag clears when the status OUT is ACKed, when host_ack follows a zero-length packet, or when a new SETUP arrives. A completed status stage ends the transfer, and later IN and OUT tokens get NAK.
- R7: Firmware may set the status flag right after SETUP with no data stage in between.
- R8: While stall is set and ep_iso is low, IN and OUT tokens get STALL (response code 2). With ep_iso high, stall has no effect.
- R9: The toggle flips only on a successful handshake: a device ACK of an OUT, or a host_ack after send-data or send-zero-length. NAK and STALL leave it unchanged, and setting stall does not reset it.
- R10: While ep_enable is low, toggle is held at 0, tokens get no response and the responder ignores host_ack.
- R11: rsp_valid is high for exactly one cycle, one clock after an accepted token. Token code 3 is reserved and gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_enable | input | 1 | Endpoint enabled; low resets toggle |
| ep_iso | input | 1 | Endpoint is isochronous; disables stall |
| tok_valid | input | 1 | Decoded token strobe |
| tok_type | input | 2 | 0 SETUP, 1 IN, 2 OUT, 3 reserved |
| data_ready | input | 1 | Transmit buffer holds a validated packet |
| host_ack | input | 1 | Host ACKed the last packet sent |
| fw_dsen_set | input | 1 | Firmware arms the data stage |
| fw_status_set | input | 1 | Firmware arms the status stage |
| fw_stall_set | input | 1 | Firmware sets stall |
| fw_stall_clr | input | 1 | Firmware clears stall |
| rsp_valid | output | 1 | Response code valid |
| rsp_code | output | 3 | 0 NAK, 1 ACK, 2 STALL, 3 send data, 4 send zero-length |
| setup_done | output | 1 | One-cycle pulse on setup acceptance |
| toggle | output | 1 | Current data toggle (0 DATA0, 1 DATA1) |
| dsen_rd | output | 1 | Read view of the data-stage flag, always 0 |

## Verification
The assertions assume the inputs were low during reset. They also assume a token strobe and a host_ack never coincide, and that firmware strobes never land in the same cycle as a token that would clear the same flag. The bench drives every stimulus from the falling edge as single-cycle pulses and keeps them apart, one per cycle. It sweeps data-stage direction and length over complete transfers, and it predicts each toggle value arithmetically from the count of successful handshakes.

// File: rtl/ctl_hs_pkg.sv
package ctl_hs_pkg;
  localparam int TOK_W = 2;
  localparam int RSP_W = 3;

  typedef enum logic [TOK_W-1:0] {
    TOK_SETUP = 2'd0,
    TOK_IN    = 2'd1,
    TOK_OUT   = 2'd2,
    TOK_RSVD  = 2'd3
  } tok_e;

  typedef enum logic [RSP_W-1:0] {
    RSP_NAK   = 3'd0,
    RSP_ACK   = 3'd1,
    RSP_STALL = 3'd2,
    RSP_DATA  = 3'd3,
    RSP_ZLP   = 3'd4
  } rsp_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_DATA = 2'd1,
    PEND_ZLP  = 2'd2
  } pend_e;
endpackage

// File: rtl/hs_flag.sv
module hs_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (set) q_nxt = 1'b1;
    if (clr) q_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/hs_toggle.sv
module hs_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic zero,
  input  logic load_one,
  input  logic flip,
  output logic q
);
  logic q_nxt;

  always_comb begin
    if (zero)          q_nxt = 1'b0;
    else if (load_one) q_nxt = 1'b1;
    else if (flip)     q_nxt = ~q;
    else               q_nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/hs_decide.sv
module hs_decide
  import ctl_hs_pkg::*;
(
  input  logic [TOK_W-1:0] tok,
  input  logic             in_xfer,
  input  logic             stall_on,
  input  logic             dsen,
  input  logic             sts,
  input  logic             data_ready,
  output logic             answer,
  output logic [RSP_W-1:0] code,
  output logic             is_setup,
  output logic             data_out_done,
  output logic             sts_out_done
);
  always_comb begin
    answer        = 1'b1;
    code          = RSP_NAK;
    is_setup      = 1'b0;
    data_out_done = 1'b0;
    sts_out_done  = 1'b0;
    case (tok_e'(tok))
      TOK_SETUP: begin
        code     = RSP_ACK;
        is_setup = 1'b1;
      end
      TOK_IN, TOK_OUT: begin
        if (stall_on) begin
          code = RSP_STALL;
        end else if (in_xfer && sts) begin
          if (tok_e'(tok) == TOK_IN) begin
            code = RSP_ZLP;
          end else begin
            code         = RSP_ACK;
            sts_out_done = 1'b1;
          end
        end else if (in_xfer && dsen) begin
          if (tok_e'(tok) == TOK_IN) begin
            code = data_ready ? RSP_DATA : RSP_NAK;
          end else begin
            code          = RSP_ACK;
            data_out_done = 1'b1;
          end
        end
      end
      default: answer = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctl_hs_responder.sv
module ctl_hs_responder
  import ctl_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ep_enable,
  input  logic             ep_iso,
  input  logic             tok_valid,
  input  logic [TOK_W-1:0] tok_type,
  input  logic             data_ready,
  input  logic             host_ack,
  input  logic             fw_dsen_set,
  input  logic             fw_status_set,
  input  logic             fw_stall_set,
  input  logic             fw_stall_clr,
  output logic             rsp_valid,
  output logic [RSP_W-1:0] rsp_code,
  output logic             setup_done,
  output logic             toggle,
  output logic             dsen_rd
);
  logic             stall_q, dsen_q, sts_q, in_xfer_q, in_xfer_nxt;
  logic             answer, is_setup, data_out_done, sts_out_done;
  logic [RSP_W-1:0] code;
  pend_e            pend_q, pend_nxt;
  logic             tok_fire, ack_fire, setup_fire, sts_done, flip;

  hs_decide u_decide (
    .tok(tok_type), .in_xfer(in_xfer_q), .stall_on(stall_q && !ep_iso),
    .dsen(dsen_q), .sts(sts_q), .data_ready(data_ready),
    .answer(answer), .code(code), .is_setup(is_setup),
    .data_out_done(data_out_done), .sts_out_done(sts_out_done)
  );

  assign tok_fire   = tok_valid && ep_enable && answer;
  assign setup_fire = tok_fire && is_setup;
  assign ack_fire   = host_ack && ep_enable && !tok_valid && (pend_q != PEND_NONE);
  assign sts_done   = (tok_fire && sts_out_done) || (ack_fire && pend_q == PEND_ZLP);
  assign flip       = (tok_fire && !is_setup && code == RSP_ACK) || ack_fire;

  hs_flag u_stall (.clk(clk), .rst_n(rst_n), .set(fw_stall_set),
                   .clr(fw_stall_clr || setup_fire), .q(stall_q));
  hs_flag u_dsen (.clk(clk), .rst_n(rst_n), .set(fw_dsen_set),
                  .clr(setup_fire || (tok_fire && data_out_done) ||
                       (ack_fire && pend_q == PEND_DATA)),
                  .q(dsen_q));
  hs_flag u_sts (.clk(clk), .rst_n(rst_n), .set(fw_status_set),
                 .clr(setup_fire || sts_done), .q(sts_q));
  hs_toggle u_tog (.clk(clk), .rst_n(rst_n), .zero(!ep_enable),
                   .load_one(setup_fire), .flip(flip), .q(toggle));

  always_comb begin
    pend_nxt = pend_q;
    if (!ep_enable)    pend_nxt = PEND_NONE;
    else if (tok_fire) pend_nxt = (code == RSP_DATA) ? PEND_DATA :
                                  (code == RSP_ZLP)  ? PEND_ZLP  : PEND_NONE;
    else if (ack_fire) pend_nxt = PEND_NONE;
    in_xfer_nxt = in_xfer_q;
    if (setup_fire)    in_xfer_nxt = 1'b1;
    else if (sts_done) in_xfer_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= PEND_NONE;
      in_xfer_q  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_code   <= RSP_NAK;
      setup_done <= 1'b0;
    end else begin
      pend_q     <= pend_nxt;
      in_xfer_q  <= in_xfer_nxt;
      rsp_valid  <= tok_fire;
      setup_done <= setup_fire;
      if (tok_fire) rsp_code <= code;
    end
  end

  assign dsen_rd = 1'b0;
endmodule

// File: rtl/ctl_hs_checker.sv
module ctl_hs_checker
  import ctl_hs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ep_enable,
  input logic             ep_iso,
  input logic             tok_valid,
  input logic [TOK_W-1:0] tok_type,
  input logic             stall_q,
  input logic             rsp_valid,
  input logic [RSP_W-1:0] rsp_code,
  input logic             setup_done,
  input logic             toggle
);
  AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && ep_enable && tok_type == TOK_SETUP |=>
      rsp_valid && rsp_code == RSP_ACK && setup_done && toggle); // R1

  AST_STALL_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && ep_enable && stall_q && !ep_iso &&
    (tok_type == TOK_IN || tok_type == TOK_OUT) |=>
      rsp_valid && rsp_code == RSP_STALL); // R8

  AST_REFUSAL_KEEPS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_code == RSP_NAK || rsp_code == RSP_STALL) &&
    $past(ep_enable) |-> $stable(toggle)); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_enable |=> !toggle && !rsp_valid); // R10

  AST_RSP_FOLLOWS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(tok_valid && ep_enable && tok_type != TOK_RSVD)); // R11

  AST_ZLP_ONLY_FOR_IN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == RSP_ZLP |-> $past(tok_type) == TOK_IN); // R5
endmodule

bind ctl_hs_responder ctl_hs_checker i_chk (.*);

// File: tb/test_ctl_hs_responder.sv
`timescale 1ns/1ps
module test_ctl_hs_responder;
  import ctl_hs_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ep_enable = 1'b0, ep_iso = 1'b0, tok_valid = 1'b0, data_ready = 1'b0;
  logic host_ack = 1'b0, fw_dsen_set = 1'b0, fw_status_set = 1'b0;
  logic fw_stall_set = 1'b0, fw_stall_clr = 1'b0;
  logic [TOK_W-1:0] tok_type = '0;
  logic rsp_valid, setup_done, toggle, dsen_rd;
  logic [RSP_W-1:0] rsp_code;
  int n_chk = 0, n_bad = 0;
  logic exp_t;

  always #5 clk = ~clk;

  ctl_hs_responder i_ctl_hs_responder (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_tok(input logic [TOK_W-1:0] t);
    tok_valid = 1'b1; tok_type = t;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic send(input logic [TOK_W-1:0] t, input logic [RSP_W-1:0] exp, input string req);
    pulse_tok(t);
    chk(rsp_valid === 1'b1 && rsp_code === exp, req, int'(rsp_code), int'(exp));
  endtask

  task automatic chk_tog(input string req);
    chk(toggle === exp_t, req, int'(toggle), int'(exp_t));
  endtask

  task automatic hack();
    host_ack = 1'b1; @(negedge clk); host_ack = 1'b0;
  endtask
  task automatic set_dsen();
    fw_dsen_set = 1'b1; @(negedge clk); fw_dsen_set = 1'b0;
  endtask
  task automatic set_sts();
    fw_status_set = 1'b1; @(negedge clk); fw_status_set = 1'b0;
  endtask
  task automatic set_stall();
    fw_stall_set = 1'b1; @(negedge clk); fw_stall_set = 1'b0;
  endtask

  task automatic do_setup();
    send(TOK_SETUP, RSP_ACK, "R1");
    chk(setup_done === 1'b1, "R1 setup_done", int'(setup_done), 1);
    exp_t = 1'b1; chk_tog("R1 toggle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0 && toggle === 1'b0 && setup_done === 1'b0, "R11 reset",
        int'(rsp_valid) + int'(toggle), 0);
    rst_n = 1'b1; ep_enable = 1'b1;
    @(negedge clk);

    // Sweep: data direction x data-stage length, full transfers
    for (int dir = 0; dir < 2; dir++) begin
      for (int n = 0; n < 4; n++) begin
        logic [TOK_W-1:0] dtok, stok;
        dtok = (dir == 0) ? TOK_IN : TOK_OUT;
        stok = (n == 0 || dir == 1) ? TOK_IN : TOK_OUT;
        do_setup();
        chk(setup_done === 1'b1, "R7 setup then status", 1, 1);
        send(dtok, RSP_NAK, "R2 unarmed data stage");
        chk_tog("R9 NAK keeps toggle");
        for (int i = 0; i < n; i++) begin
          set_dsen();
          chk(dsen_rd === 1'b0, "R4 dsen_rd", int'(dsen_rd), 0);
          if (dir == 0) begin
            data_ready = 1'b1;
            send(TOK_IN, RSP_DATA, "R3 IN data");
            data_ready = 1'b0;
            hack();
          end else begin
            send(TOK_OUT, RSP_ACK, "R3 OUT ack");
          end
          exp_t = ~exp_t; chk_tog("R9 toggle flips");
          send(dtok, RSP_NAK, "R3 dsen self-clears");
        end
        send(stok, RSP_NAK, "R5 status unarmed");
        set_sts();
        if (stok == TOK_IN) begin
          send(TOK_IN, RSP_ZLP, "R5 status IN zlp");
          hack();
        end else begin
          send(TOK_OUT, RSP_ACK, "R5 status OUT ack");
        end
        exp_t = ~exp_t; chk_tog("R9 status toggle");
        send(stok, RSP_NAK, "R6 status completed");
      end
    end

    // IN with dsen but no data waits
    do_setup();
    set_dsen();
    send(TOK_IN, RSP_NAK, "R3 no data ready");
    data_ready = 1'b1;
    send(TOK_IN, RSP_DATA, "R3 data after wait");
    data_ready = 1'b0;
    hack(); exp_t = 1'b0; chk_tog("R9");

    // Stall keeps toggle, SETUP overrides and clears stall
    set_stall();
    send(TOK_IN, RSP_STALL, "R8 stall IN");
    send(TOK_OUT, RSP_STALL, "R8 stall OUT");
    chk_tog("R9 stall keeps toggle");
    do_setup();
    send(TOK_IN, RSP_NAK, "R1 stall cleared");

    // Isochronous ignores stall
    ep_iso = 1'b1;
    set_stall();
    send(TOK_IN, RSP_NAK, "R8 iso no stall");
    ep_iso = 1'b0;
    send(TOK_IN, RSP_STALL, "R8 non-iso stall");
    fw_stall_clr = 1'b1; @(negedge clk); fw_stall_clr = 1'b0;

    // SETUP clears armed status
    do_setup();
    set_sts();
    do_setup();
    send(TOK_OUT, RSP_NAK, "R6 SETUP clears status");

    // Status takes priority over data stage
    set_dsen(); set_sts();
    send(TOK_IN, RSP_ZLP, "R5 status priority");
    hack();

    // Reserved token
    pulse_tok(TOK_RSVD);
    chk(rsp_valid === 1'b0, "R11 reserved token", int'(rsp_valid), 0);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R11 single-cycle rsp", int'(rsp_valid), 0);

    // Disable resets toggle, ignores tokens
    do_setup();
    ep_enable = 1'b0;
    @(negedge clk);
    chk(toggle === 1'b0, "R10 disable clears toggle", int'(toggle), 0);
    pulse_tok(TOK_SETUP);
    chk(rsp_valid === 1'b0, "R10 disabled no response", int'(rsp_valid), 0);
    ep_enable = 1'b1;
    @(negedge clk);
    chk(toggle === 1'b0, "R10 re-enabled DATA0", int'(toggle), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule